// File: doc/BRIEF.md
# Tiered Priority Interrupt Resolver

This block turns a coarse vector of pending interrupt groups into a single chosen interrupt number. Several groups stand for a cluster of finer events. For the memory-protection, DSP, audio-stream and expansion-bus groups, the block reads each group's own status word. It then builds a 27-entry fine cause vector. Index 0 sits in the most significant bit of a 32-bit word, and the five least significant bits stay zero.

Two software mask words remove causes before selection. Their bits use the same numbering as the fine vector. A hardware mask acts only as a gate: if no coarse bit overlaps it, no interrupt is reported at all. The winner comes from a fixed list of ten tiers. Each tier is a set of fine indices. The first tier that holds a surviving cause wins, and inside that tier the lowest index wins.

A strobe starts each resolution, and the result is registered. A free-running timestamp counter provides the time for a record of the last interrupt. That record is updated only when the winner's index is 5 or higher.

Top module: `irq_tier_resolver`

## Requirements
- R1: While reset is held and in the first cycle after it, `win_valid_o`, `win_idx_o`, `last_idx_o` and `last_time_o` are all zero.
- R2: The fine vector is numbered with index i at bit 31-i, and each index maps to one source as follows.
  - Memory group (coarse bit 7): status bits 0..4 give indices 0..4.
  - DSP group (coarse bit 6): status bits 3, 5 and 7 give indices 5, 6 and 7.
  - Audio group (coarse bit 5): status bit 3 gives index 8.
  - Expansion-bus group (coarse bit 4): on channels 0, 1 and 2, status bit 1 is the device flag, bit 3 is transfer complete and bit 11 is attach. These give indices 9..16 in channel order (device, transfer complete, attach), and channel 2 has no attach flag.
  - Direct coarse bits: bit 11 gives 17, bit 9 gives 18, bit 10 gives 19, bit 3 gives 20, bit 2 gives 21, bit 1 gives 22, bit 0 gives 23, bit 8 gives 24, bit 12 gives 25 and bit 13 gives 26.
  - With one source active and the hardware mask all ones, the winner is that index.
- R3: A status word contributes fine bits only while its coarse group bit is set.
- R4: Coarse bit 16 (reset-button level) is removed before any other step, so it neither produces a cause nor satisfies the hardware-mask gate.
- R5: When the cleaned coarse vector is zero, or its AND with `hw_mask_i` is zero, no winner is reported. Otherwise the hardware mask does not filter which fine cause wins.
- R6: Every fine bit set in `sw_mask_a_i | sw_mask_b_i` is removed before selection. If nothing remains, `win_valid_o` is 0.
- R7: Tiers, from highest to lowest, are:
  1. index 23
  2. index 25
  3. indices 0..4
  4. index 22
  5. index 24
  6. indices 18 and 19
  7. index 26
  8. indices 6..16, 20 and 21
  9. index 5
  10. index 17
- R8: Within the winning tier, the lowest surviving index wins.
- R9: `win_idx_o` and `win_valid_o` take the result of a strobe one cycle after it and hold between strobes. `win_idx_o` is 0 when there is no winner.
- R10: On a strobe whose winner index is 5 or higher, `last_idx_o` takes the index and `last_time_o` takes the timestamp value present in the strobe cycle. The timestamp is 0 in the first cycle after reset and rises by one per cycle. On any other strobe the record is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_i | input | 1 | Start a resolution this cycle |
| coarse_i | input | 32 | Coarse pending groups |
| hw_mask_i | input | 32 | Hardware mask (gate only) |
| mem_stat_i | input | 16 | Memory-protection status word |
| dsp_stat_i | input | 16 | DSP control/status word |
| aud_stat_i | input | 32 | Audio stream control word |
| chan0_stat_i | input | 32 | Expansion-bus channel 0 status |
| chan1_stat_i | input | 32 | Expansion-bus channel 1 status |
| chan2_stat_i | input | 32 | Expansion-bus channel 2 status |
| sw_mask_a_i | input | 32 | Software mask, fine numbering |
| sw_mask_b_i | input | 32 | Second software mask, fine numbering |
| win_idx_o | output | 5 | Winning fine index |
| win_valid_o | output | 1 | A winner exists |
| last_idx_o | output | 5 | Last recorded winner (index 5 or higher) |
| last_time_o | output | 32 | Timestamp of the last recorded winner |

## Verification
The assertions assume that mask and coarse inputs are stable across each strobe cycle. They also assume reset is held for more than one clock, so that `$past` never sees unreset registers.

The record assertions also assume the timestamp does not wrap back to an earlier value within a run. A 32-bit counter meets this easily.

The stimulus changes inputs only at the falling edge and pulses the strobe for a single cycle. It drives each fine source alone, then every ordered pair, with and without a software mask on one member. Dedicated cases cover the gating corners: the reset-level bit, a hardware mask with no overlap, status words without their group bit, and a group bit with an empty status word.

// File: rtl/irq_tier_pkg.sv
package irq_tier_pkg;

  localparam int VEC_W         = 32;
  localparam int IDX_W         = 5;
  localparam int N_TIERS       = 10;
  localparam int N_FINE        = 27;
  localparam int N_CHAN        = 3;
  localparam int N_CHAN_ATTACH = 2;

  // coarse vector bit positions
  localparam int CB_ERR     = 0;
  localparam int CB_RSW     = 1;
  localparam int CB_DISK    = 2;
  localparam int CB_SER     = 3;
  localparam int CB_EXP     = 4;
  localparam int CB_AUD     = 5;
  localparam int CB_DSP     = 6;
  localparam int CB_MEM     = 7;
  localparam int CB_VID     = 8;
  localparam int CB_TOK     = 9;
  localparam int CB_FIN     = 10;
  localparam int CB_CMD     = 11;
  localparam int CB_DBG     = 12;
  localparam int CB_HSP     = 13;
  localparam int CB_RST_LVL = 16;

  // fine vector indices (index i lives at bit VEC_W-1-i)
  localparam int FI_MEM0  = 0;
  localparam int N_MEM    = 5;
  localparam int FI_ADMA  = 5;
  localparam int FI_ARAM  = 6;
  localparam int FI_DSP   = 7;
  localparam int FI_STRM  = 8;
  localparam int FI_EXP0  = 9;
  localparam int EXP_STEP = 3;
  localparam int FI_CMD   = 17;
  localparam int FI_TOK   = 18;
  localparam int FI_FIN   = 19;
  localparam int FI_SER   = 20;
  localparam int FI_DISK  = 21;
  localparam int FI_RSW   = 22;
  localparam int FI_ERR   = 23;
  localparam int FI_VID   = 24;
  localparam int FI_DBG   = 25;
  localparam int FI_HSP   = 26;

  // status-word bit positions
  localparam int DS_ADMA = 3;
  localparam int DS_ARAM = 5;
  localparam int DS_DSP  = 7;
  localparam int AS_STRM = 3;
  localparam int CS_DEV  = 1;
  localparam int CS_TC   = 3;
  localparam int CS_ATT  = 11;

  localparam int REC_MIN_IDX = 5;

  function automatic logic [VEC_W-1:0] fbit(input int idx);
    return {1'b1, {(VEC_W-1){1'b0}}} >> idx;
  endfunction

  // tier t = 0 is the highest priority
  function automatic logic [VEC_W-1:0] tier_mask(input int t);
    logic [VEC_W-1:0] m;
    m = '0;
    case (t)
      0: m = fbit(FI_ERR);
      1: m = fbit(FI_DBG);
      2: for (int i = FI_MEM0; i < FI_MEM0 + N_MEM; i++) m |= fbit(i);
      3: m = fbit(FI_RSW);
      4: m = fbit(FI_VID);
      5: m = fbit(FI_TOK) | fbit(FI_FIN);
      6: m = fbit(FI_HSP);
      7: begin
        m = fbit(FI_ARAM) | fbit(FI_DSP) | fbit(FI_STRM) | fbit(FI_SER) | fbit(FI_DISK);
        for (int i = FI_EXP0; i < FI_CMD; i++) m |= fbit(i);
      end
      8: m = fbit(FI_ADMA);
      9: m = fbit(FI_CMD);
      default: m = '0;
    endcase
    return m;
  endfunction

  function automatic logic [IDX_W-1:0] lead_zeros(input logic [VEC_W-1:0] v);
    logic [IDX_W-1:0] n;
    logic             found;
    n = '0;
    found = 1'b0;
    for (int i = 0; i < VEC_W; i++) begin
      if (!found && v[VEC_W-1-i]) begin
        n = IDX_W'(i);
        found = 1'b1;
      end
    end
    return n;
  endfunction

endpackage

// File: rtl/irq_fine_expand.sv
module irq_fine_expand
  import irq_tier_pkg::*;
(
  input  logic [VEC_W-1:0]             coarse_raw,
  input  logic [VEC_W-1:0]             hw_mask,
  input  logic [15:0]                  mem_stat,
  input  logic [15:0]                  dsp_stat,
  input  logic [31:0]                  aud_stat,
  input  logic [N_CHAN-1:0][31:0]      chan_stat,
  output logic [VEC_W-1:0]             fine,
  output logic                         gate_ok
);

  logic [VEC_W-1:0] coarse;
  logic [VEC_W-1:0] fine_mem;
  logic [VEC_W-1:0] fine_dsp;
  logic [VEC_W-1:0] fine_dir;
  logic [N_CHAN-1:0][VEC_W-1:0] fine_chan;
  logic [VEC_W-1:0] fine_exp;

  assign coarse  = coarse_raw & ~(VEC_W'(1) << CB_RST_LVL);
  assign gate_ok = (|coarse) && (|(coarse & hw_mask));

  always_comb begin
    fine_mem = '0;
    for (int g = 0; g < N_MEM; g++)
      if (coarse[CB_MEM] && mem_stat[g]) fine_mem |= fbit(FI_MEM0 + g);
  end

  always_comb begin
    fine_dsp = '0;
    if (coarse[CB_DSP]) begin
      if (dsp_stat[DS_ADMA]) fine_dsp |= fbit(FI_ADMA);
      if (dsp_stat[DS_ARAM]) fine_dsp |= fbit(FI_ARAM);
      if (dsp_stat[DS_DSP])  fine_dsp |= fbit(FI_DSP);
    end
    if (coarse[CB_AUD] && aud_stat[AS_STRM]) fine_dsp |= fbit(FI_STRM);
  end

  genvar c;
  generate
    for (c = 0; c < N_CHAN; c++) begin : g_chan
      localparam int BASE = FI_EXP0 + EXP_STEP * c;
      logic [VEC_W-1:0] att_bit;
      if (c < N_CHAN_ATTACH) begin : g_att
        assign att_bit = chan_stat[c][CS_ATT] ? fbit(BASE + 2) : '0;
      end else begin : g_noatt
        assign att_bit = '0;
      end
      assign fine_chan[c] = coarse[CB_EXP] ?
        ((chan_stat[c][CS_DEV] ? fbit(BASE) : '0) |
         (chan_stat[c][CS_TC]  ? fbit(BASE + 1) : '0) |
         att_bit) : '0;
    end
  endgenerate

  always_comb begin
    fine_exp = '0;
    for (int k = 0; k < N_CHAN; k++) fine_exp |= fine_chan[k];
  end

  always_comb begin
    fine_dir = '0;
    if (coarse[CB_CMD])  fine_dir |= fbit(FI_CMD);
    if (coarse[CB_TOK])  fine_dir |= fbit(FI_TOK);
    if (coarse[CB_FIN])  fine_dir |= fbit(FI_FIN);
    if (coarse[CB_SER])  fine_dir |= fbit(FI_SER);
    if (coarse[CB_DISK]) fine_dir |= fbit(FI_DISK);
    if (coarse[CB_RSW])  fine_dir |= fbit(FI_RSW);
    if (coarse[CB_ERR])  fine_dir |= fbit(FI_ERR);
    if (coarse[CB_VID])  fine_dir |= fbit(FI_VID);
    if (coarse[CB_DBG])  fine_dir |= fbit(FI_DBG);
    if (coarse[CB_HSP])  fine_dir |= fbit(FI_HSP);
  end

  assign fine = fine_mem | fine_dsp | fine_exp | fine_dir;

  // status bits with no meaning for this block
  logic unused_stat;
  assign unused_stat = ^{mem_stat[15:N_MEM], dsp_stat[15:8], dsp_stat[6], dsp_stat[4],
                         dsp_stat[2:0], aud_stat[31:4], aud_stat[2:0],
                         chan_stat[0][31:12], chan_stat[0][10:4], chan_stat[0][2], chan_stat[0][0],
                         chan_stat[1][31:12], chan_stat[1][10:4], chan_stat[1][2], chan_stat[1][0],
                         chan_stat[2][31:4], chan_stat[2][2], chan_stat[2][0]};

endmodule

// File: rtl/irq_tier_pick.sv
module irq_tier_pick
  import irq_tier_pkg::*;
(
  input  logic [VEC_W-1:0] cause,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);

  logic [N_TIERS-1:0][VEC_W-1:0] tier_and;

  genvar t;
  generate
    for (t = 0; t < N_TIERS; t++) begin : g_tier
      assign tier_and[t] = cause & tier_mask(t);
    end
  endgenerate

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int k = 0; k < N_TIERS; k++) begin
      if (!hit && (|tier_and[k])) begin
        hit = 1'b1;
        idx = lead_zeros(tier_and[k]);
      end
    end
  end

endmodule

// File: rtl/irq_stamp_counter.sv
module irq_stamp_counter #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  output logic [TS_W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count + TS_W'(1);
  end

endmodule

// File: rtl/irq_tier_resolver.sv
module irq_tier_resolver
  import irq_tier_pkg::*;
#(
  parameter int TS_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe_i,
  input  logic [31:0]      coarse_i,
  input  logic [31:0]      hw_mask_i,
  input  logic [15:0]      mem_stat_i,
  input  logic [15:0]      dsp_stat_i,
  input  logic [31:0]      aud_stat_i,
  input  logic [31:0]      chan0_stat_i,
  input  logic [31:0]      chan1_stat_i,
  input  logic [31:0]      chan2_stat_i,
  input  logic [31:0]      sw_mask_a_i,
  input  logic [31:0]      sw_mask_b_i,
  output logic [4:0]       win_idx_o,
  output logic             win_valid_o,
  output logic [4:0]       last_idx_o,
  output logic [TS_W-1:0]  last_time_o
);

  localparam logic [IDX_W-1:0] REC_MIN = IDX_W'(REC_MIN_IDX);

  logic [N_CHAN-1:0][31:0] chan_pack;
  logic [VEC_W-1:0]        fine;
  logic [VEC_W-1:0]        survivors;
  logic                    gate_ok;
  logic                    hit;
  logic [IDX_W-1:0]        idx;
  logic [TS_W-1:0]         stamp;
  logic                    win_now;

  assign chan_pack[0] = chan0_stat_i;
  assign chan_pack[1] = chan1_stat_i;
  assign chan_pack[2] = chan2_stat_i;

  irq_fine_expand u_expand (
    .coarse_raw (coarse_i),
    .hw_mask    (hw_mask_i),
    .mem_stat   (mem_stat_i),
    .dsp_stat   (dsp_stat_i),
    .aud_stat   (aud_stat_i),
    .chan_stat  (chan_pack),
    .fine       (fine),
    .gate_ok    (gate_ok)
  );

  assign survivors = fine & ~(sw_mask_a_i | sw_mask_b_i);

  irq_tier_pick u_pick (
    .cause (survivors),
    .hit   (hit),
    .idx   (idx)
  );

  irq_stamp_counter #(.TS_W(TS_W)) u_stamp (
    .clk   (clk),
    .rst   (rst),
    .count (stamp)
  );

  assign win_now = gate_ok && hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_valid_o <= 1'b0;
      win_idx_o   <= '0;
      last_idx_o  <= '0;
      last_time_o <= '0;
    end else if (strobe_i) begin
      win_valid_o <= win_now;
      win_idx_o   <= win_now ? idx : '0;
      if (win_now && idx >= REC_MIN) begin
        last_idx_o  <= idx;
        last_time_o <= stamp;
      end
    end
  end

endmodule

// File: rtl/irq_tier_resolver_chk.sv
module irq_tier_resolver_chk #(
  parameter int TS_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            strobe_i,
  input logic [31:0]     coarse_i,
  input logic [31:0]     hw_mask_i,
  input logic [31:0]     sw_mask_a_i,
  input logic [31:0]     sw_mask_b_i,
  input logic [4:0]      win_idx_o,
  input logic            win_valid_o,
  input logic [4:0]      last_idx_o,
  input logic [TS_W-1:0] last_time_o
);

  localparam logic [31:0] LEVEL_BIT = 32'h0001_0000;

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(strobe_i) |-> ($stable(win_idx_o) && $stable(win_valid_o)));

  assert_gate_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(strobe_i) && (($past(coarse_i) & ~LEVEL_BIT & $past(hw_mask_i)) == 32'h0))
      |-> !win_valid_o);

  assert_masked_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(strobe_i) && win_valid_o)
      |-> (((($past(sw_mask_a_i) | $past(sw_mask_b_i)) << win_idx_o) & 32'h8000_0000) == 32'h0));

  assert_range_R2: assert property (@(posedge clk) disable iff (rst)
    win_valid_o |-> (win_idx_o <= 5'd26));

  assert_record_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(strobe_i) && win_valid_o && (win_idx_o >= 5'd5)) |-> (last_idx_o == win_idx_o));

  assert_record_only_R10: assert property (@(posedge clk) disable iff (rst)
    (!$stable(last_idx_o) || !$stable(last_time_o))
      |-> ($past(strobe_i) && win_valid_o && (win_idx_o >= 5'd5)));

endmodule

bind irq_tier_resolver irq_tier_resolver_chk #(.TS_W(TS_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .strobe_i    (strobe_i),
  .coarse_i    (coarse_i),
  .hw_mask_i   (hw_mask_i),
  .sw_mask_a_i (sw_mask_a_i),
  .sw_mask_b_i (sw_mask_b_i),
  .win_idx_o   (win_idx_o),
  .win_valid_o (win_valid_o),
  .last_idx_o  (last_idx_o),
  .last_time_o (last_time_o)
);

// File: tb/irq_tier_resolver_tb.sv
module irq_tier_resolver_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TS_W       = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strobe = 1'b0;
  logic [31:0] coarse = '0, hwm = '0, aud = '0, c0 = '0, c1 = '0, c2 = '0, swa = '0, swb = '0;
  logic [15:0] mem = '0, dsp = '0;
  logic [4:0]  win_idx, last_idx;
  logic        win_valid;
  logic [TS_W-1:0] last_time;

  int errors = 0;
  int checks = 0;
  logic [31:0] tb_cnt = '0;
  int exp_last_idx = 0;
  logic [31:0] exp_last_time = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) tb_cnt <= '0;
    else     tb_cnt <= tb_cnt + 32'd1;
  end

  irq_tier_resolver #(.TS_W(TS_W)) u_dut (
    .clk(clk), .rst(rst), .strobe_i(strobe), .coarse_i(coarse), .hw_mask_i(hwm),
    .mem_stat_i(mem), .dsp_stat_i(dsp), .aud_stat_i(aud),
    .chan0_stat_i(c0), .chan1_stat_i(c1), .chan2_stat_i(c2),
    .sw_mask_a_i(swa), .sw_mask_b_i(swb),
    .win_idx_o(win_idx), .win_valid_o(win_valid),
    .last_idx_o(last_idx), .last_time_o(last_time)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_stim();
    coarse = '0; hwm = 32'hFFFF_FFFF; mem = '0; dsp = '0; aud = '0;
    c0 = '0; c1 = '0; c2 = '0; swa = '0; swb = '0;
  endtask

  // tier rank from the requirement list (0 = highest)
  function automatic int rank(input int i);
    if (i == 23) return 0;
    if (i == 25) return 1;
    if (i <= 4) return 2;
    if (i == 22) return 3;
    if (i == 24) return 4;
    if (i == 18 || i == 19) return 5;
    if (i == 26) return 6;
    if (i == 5) return 8;
    if (i == 17) return 9;
    return 7;
  endfunction

  task automatic add_fine(input int i);
    int ch, k;
    logic [31:0] v;
    if (i <= 4) begin coarse[7] = 1'b1; mem[i] = 1'b1; end
    else if (i == 5) begin coarse[6] = 1'b1; dsp[3] = 1'b1; end
    else if (i == 6) begin coarse[6] = 1'b1; dsp[5] = 1'b1; end
    else if (i == 7) begin coarse[6] = 1'b1; dsp[7] = 1'b1; end
    else if (i == 8) begin coarse[5] = 1'b1; aud[3] = 1'b1; end
    else if (i <= 16) begin
      coarse[4] = 1'b1;
      ch = (i - 9) / 3; k = (i - 9) % 3;
      v = (k == 0) ? 32'h2 : (k == 1) ? 32'h8 : 32'h800;
      if (ch == 0) c0 |= v; else if (ch == 1) c1 |= v; else c2 |= v;
    end
    else case (i)
      17: coarse[11] = 1'b1;
      18: coarse[9]  = 1'b1;
      19: coarse[10] = 1'b1;
      20: coarse[3]  = 1'b1;
      21: coarse[2]  = 1'b1;
      22: coarse[1]  = 1'b1;
      23: coarse[0]  = 1'b1;
      24: coarse[8]  = 1'b1;
      25: coarse[12] = 1'b1;
      default: coarse[13] = 1'b1;
    endcase
  endtask

  // expected winner from the requirement text; -1 = none
  function automatic int model();
    logic [31:0] c, f;
    int best;
    c = coarse & ~32'h0001_0000;
    if (c == 0 || (c & hwm) == 0) return -1;
    f = '0;
    if (c[7]) for (int g = 0; g < 5; g++) if (mem[g]) f[31-g] = 1'b1;
    if (c[6]) begin
      if (dsp[3]) f[31-5] = 1'b1;
      if (dsp[5]) f[31-6] = 1'b1;
      if (dsp[7]) f[31-7] = 1'b1;
    end
    if (c[5] && aud[3]) f[31-8] = 1'b1;
    if (c[4]) begin
      if (c0[1]) f[31-9] = 1'b1;  if (c0[3]) f[31-10] = 1'b1; if (c0[11]) f[31-11] = 1'b1;
      if (c1[1]) f[31-12] = 1'b1; if (c1[3]) f[31-13] = 1'b1; if (c1[11]) f[31-14] = 1'b1;
      if (c2[1]) f[31-15] = 1'b1; if (c2[3]) f[31-16] = 1'b1;
    end
    if (c[11]) f[31-17] = 1'b1; if (c[9])  f[31-18] = 1'b1; if (c[10]) f[31-19] = 1'b1;
    if (c[3])  f[31-20] = 1'b1; if (c[2])  f[31-21] = 1'b1; if (c[1])  f[31-22] = 1'b1;
    if (c[0])  f[31-23] = 1'b1; if (c[8])  f[31-24] = 1'b1; if (c[12]) f[31-25] = 1'b1;
    if (c[13]) f[31-26] = 1'b1;
    f &= ~(swa | swb);
    best = -1;
    for (int i = 0; i < 27; i++)
      if (f[31-i] && (best < 0 || rank(i) < rank(best))) best = i;
    return best;
  endfunction

  task automatic fire(input string req);
    int exp;
    logic [31:0] ts;
    @(negedge clk);
    exp = model();
    ts = tb_cnt;
    strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
    if (exp >= 5) begin exp_last_idx = exp; exp_last_time = ts; end
    chk(win_valid == (exp >= 0), req, win_valid, exp >= 0);
    chk(win_idx == ((exp >= 0) ? exp : 0), req, win_idx, (exp >= 0) ? exp : 0);
    chk(last_idx == exp_last_idx, "R10 idx", last_idx, exp_last_idx);
    chk(last_time == exp_last_time, "R10 time", last_time, exp_last_time);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    clear_stim();
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(win_valid == 1'b0 && win_idx == 5'd0, "R1 win", {win_valid, win_idx}, 0);
    chk(last_idx == 5'd0 && last_time == '0, "R1 rec", last_time, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(win_valid == 1'b0 && last_time == '0, "R1 after", last_time, 0);

    // R2: each fine source alone
    for (int i = 0; i < 27; i++) begin
      clear_stim(); add_fine(i); fire("R2 single");
    end

    // R7 / R8 pairs, and R6 masking one member
    for (int a = 0; a < 27; a++) begin
      for (int b = 0; b < 27; b++) begin
        if (a == b) continue;
        clear_stim(); add_fine(a); add_fine(b);
        fire((rank(a) == rank(b)) ? "R8 pair" : "R7 pair");
        if ((a + b) % 2 == 0) swa = 32'h8000_0000 >> a;
        else                  swb = 32'h8000_0000 >> a;
        fire("R6 mask");
      end
    end

    // R6: everything masked
    clear_stim(); for (int i = 0; i < 27; i++) add_fine(i);
    swa = 32'hFFFF_0000; swb = 32'h0000_FFFF; fire("R6 all");

    // R3: status words without their group bits
    clear_stim(); coarse = 32'h100; mem = 16'h1F; dsp = 16'hA8; aud = 32'h8;
    c0 = 32'h80A; c1 = 32'h80A; c2 = 32'h80A; fire("R3 no group");
    chk(win_idx == 5'd24, "R3 video", win_idx, 24);
    clear_stim(); coarse = 32'h80; fire("R3 empty word");
    chk(win_valid == 1'b0, "R3 empty", win_valid, 0);
    // R2: channel 2 attach bit ignored
    clear_stim(); coarse = 32'h10; c2 = 32'h800; fire("R2 ch2 attach");

    // R4: level bit stripped
    clear_stim(); coarse = 32'h0001_0000; fire("R4 level only");
    clear_stim(); coarse = 32'h0001_0100; hwm = 32'h0001_0000; fire("R4 level gate");

    // R5: hardware mask gate
    clear_stim(); coarse = 32'h100; hwm = ~32'h100; fire("R5 gate shut");
    clear_stim(); coarse = 32'h101; hwm = 32'h100; fire("R5 gate open");
    chk(win_idx == 5'd23, "R5 no filter", win_idx, 23);

    // R9: hold between strobes
    clear_stim(); add_fine(24); fire("R9 load");
    clear_stim(); add_fine(0);
    repeat (3) @(negedge clk);
    chk(win_valid == 1'b1 && win_idx == 5'd24, "R9 hold", win_idx, 24);

    // R10: low index keeps record
    clear_stim(); add_fine(2); fire("R10 low index");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule